// File: doc/BRIEF.md
# Frequency Tuning Word Slew Limiter

This block bounds how quickly the tuning word of a DDS-based clock synthesizer may change. It sits after the digital loop filter and before the smoothing filter that feeds the phase accumulator. It takes a 48-bit target tuning word and produces a 48-bit output word. When limiting is active, the output is updated only once every 2^P clocks. On each update it moves toward the target by at most a programmable 48-bit constant K. The resulting frequency ramp rate is K·fS²/(2^48·2^P).

When limiting is off, the output is a registered copy of the target. The internal word is reloaded on every clock, so turning the limiter back on never causes a jump. On an update the distance to the target is taken as a true signed quantity one bit wider than the tuning word. A target numerically below the current word therefore always produces a downward step, even when the two values lie on opposite sides of the 48-bit wrap point. Writing a new exponent restarts the update cadence.

Top module: `ftw_slew_limiter`

## Requirements
- R1: While reset is asserted, and on the first sample after its release, `out_tw` is 0.
- R2: With `lim_en` low, `out_tw` equals the value `target_tw` had at the previous rising clock edge, on every clock.
- R3: With `lim_en` high, `out_tw` changes only on update edges. Update edges are every 2^`rate_exp`-th consecutive enabled edge, counted from the edge where enabling starts or from the last restart. Between update edges, `out_tw` holds its value.
- R4: On an update edge where `target_tw` exceeds `out_tw` (both unsigned) by more than `slew_k`, `out_tw` increases by exactly `slew_k`.
- R5: On an update edge where `target_tw` is below `out_tw` by more than `slew_k`, `out_tw` decreases by exactly `slew_k`.
- R6: On an update edge where the unsigned distance between `target_tw` and `out_tw` is at most `slew_k` (equality included), `out_tw` becomes exactly `target_tw`.
- R7: The step direction follows the plain unsigned comparison of the two 48-bit words. A step never wraps through 0 or 2^48−1, and `out_tw` never passes beyond the target.
- R8: With `slew_k` = 0 and `lim_en` high, `out_tw` stays frozen at its current value.
- R9: When `lim_en` rises, `out_tw` keeps the last bypassed value until the first update edge. There is no jump on enabling.
- R10: A high `rate_exp_wr` on an enabled edge produces no update on that edge. The next update edge is 2^`rate_exp` enabled edges after it.
- R11: With `rate_exp` = 0 and `lim_en` high, every enabled edge without a restart is an update edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lim_en | input | 1 | 1 = limit the slew, 0 = registered bypass |
| slew_k | input | 48 | Largest change allowed per update |
| rate_exp | input | 4 | Update period exponent P (period 2^P clocks) |
| rate_exp_wr | input | 1 | Strobe marking a write of `rate_exp`; restarts the cadence |
| target_tw | input | 48 | Tuning word requested by the loop filter |
| out_tw | output | 48 | Rate-bounded tuning word |

## Verification
A wrong cadence counter shows up as an output step one or more clocks early or late relative to the 2^P boundary. It is visible on the first update after enabling or after a restart strobe. A wrong held word or a wrong step computation appears on the very next update edge. The symptom is a change different from ±K, an overshoot past the target, or a move in the wrong direction, which is exposed by starting just above the wrap point with a target just above zero. A bypass fault appears one clock after any change of the target while limiting is off.

// File: rtl/ftw_slew_pkg.sv
package ftw_slew_pkg;

    localparam int unsigned FTW_W_DEF   = 48;
    localparam int unsigned RATE_EXP_W  = 4;

    // Outcome of one bounded step toward the target
    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2,
        STEP_LAND = 2'd3
    } step_kind_e;

endpackage

// File: rtl/ftw_rate_tick.sv
module ftw_rate_tick #(
    parameter int unsigned EXP_W = ftw_slew_pkg::RATE_EXP_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [EXP_W-1:0] rate_exp,
    output logic             tick
);

    localparam int unsigned CNT_W = (1 << EXP_W) - 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tick_state_t;

    tick_state_t      st_d, st_q;
    logic [CNT_W-1:0] lim;

    // Terminal count 2^P - 1 as a mask of P low ones
    always_comb begin
        for (int i = 0; i < CNT_W; i++) begin
            lim[i] = (i < int'(rate_exp));
        end
    end

    always_comb begin
        tick = run && !restart && (st_q.cnt == lim);
        st_d = st_q;
        if (!run || restart || tick) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R3: with P > 0 two update ticks are never adjacent
    a_r3_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && rate_exp != '0) |=> !tick);

    // R11: P = 0 ticks on every running clock without restart
    a_r11_every_clock: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !restart && rate_exp == '0) |-> tick);

endmodule

// File: rtl/ftw_step_calc.sv
module ftw_step_calc
    import ftw_slew_pkg::*;
#(
    parameter int unsigned TW_W = FTW_W_DEF
) (
    input  logic [TW_W-1:0] cur,
    input  logic [TW_W-1:0] tgt,
    input  logic [TW_W-1:0] k,
    output logic [TW_W-1:0] nxt
);

    logic signed [TW_W:0] diff;
    logic signed [TW_W:0] mag;
    logic signed [TW_W:0] k_ext;
    step_kind_e           kind;

    always_comb begin
        // One extra bit keeps the sign exact across the wrap point
        diff  = $signed({1'b0, tgt}) - $signed({1'b0, cur});
        mag   = diff[TW_W] ? -diff : diff;
        k_ext = $signed({1'b0, k});
        if (diff == '0) begin
            kind = STEP_HOLD;
        end else if (mag <= k_ext) begin
            kind = STEP_LAND;
        end else if (diff[TW_W]) begin
            kind = STEP_DOWN;
        end else begin
            kind = STEP_UP;
        end
    end

    always_comb begin
        unique case (kind)
            STEP_UP:   nxt = cur + k;
            STEP_DOWN: nxt = cur - k;
            STEP_LAND: nxt = tgt;
            default:   nxt = cur;
        endcase
    end

endmodule

// File: rtl/ftw_slew_limiter.sv
module ftw_slew_limiter
    import ftw_slew_pkg::*;
#(
    parameter int unsigned TW_W  = FTW_W_DEF,
    parameter int unsigned EXP_W = RATE_EXP_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lim_en,
    input  logic [TW_W-1:0]  slew_k,
    input  logic [EXP_W-1:0] rate_exp,
    input  logic             rate_exp_wr,
    input  logic [TW_W-1:0]  target_tw,
    output logic [TW_W-1:0]  out_tw
);

    typedef struct packed {
        logic [TW_W-1:0] tw;
    } lim_state_t;

    lim_state_t      st_d, st_q;
    logic            upd_tick;
    logic [TW_W-1:0] step_nxt;

    ftw_rate_tick #(.EXP_W(EXP_W)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (lim_en),
        .restart  (rate_exp_wr),
        .rate_exp (rate_exp),
        .tick     (upd_tick)
    );

    ftw_step_calc #(.TW_W(TW_W)) u_step (
        .cur (st_q.tw),
        .tgt (target_tw),
        .k   (slew_k),
        .nxt (step_nxt)
    );

    always_comb begin
        st_d = st_q;
        if (!lim_en) begin
            st_d.tw = target_tw;
        end else if (upd_tick) begin
            st_d.tw = step_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_tw = st_q.tw;

    // R2: bypass is a one-clock registered copy
    a_r2_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        !lim_en |=> out_tw == $past(target_tw));

    // R3: no change off the update tick while limiting
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (lim_en && !upd_tick) |=> $stable(out_tw));

    // R4/R5/R6: a change is either a landing or exactly one K
    a_r4_step_size: assert property (@(posedge clk) disable iff (!rst_n)
        (lim_en && upd_tick) |=>
            (out_tw == $past(target_tw)) ||
            (out_tw == $past(out_tw) + $past(slew_k)) ||
            (out_tw == $past(out_tw) - $past(slew_k)));

    // R7: upward moves stay between old value and target
    a_r7_up_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (lim_en && upd_tick && target_tw > out_tw) |=>
            (out_tw >= $past(out_tw)) && (out_tw <= $past(target_tw)));

    // R7: downward moves stay between target and old value
    a_r7_down_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (lim_en && upd_tick && target_tw < out_tw) |=>
            (out_tw <= $past(out_tw)) && (out_tw >= $past(target_tw)));

    // R8: zero constant freezes the output
    a_r8_zero_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (lim_en && slew_k == '0) |=> $stable(out_tw));

endmodule

// File: tb/ftw_slew_limiter_tb.sv
module ftw_slew_limiter_tb;

    localparam int TW_W = 48;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            lim_en = 1'b0;
    logic [TW_W-1:0] slew_k = '0;
    logic [3:0]      rate_exp = '0;
    logic            rate_exp_wr = 1'b0;
    logic [TW_W-1:0] target_tw = '0;
    logic [TW_W-1:0] out_tw;

    ftw_slew_limiter u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .lim_en      (lim_en),
        .slew_k      (slew_k),
        .rate_exp    (rate_exp),
        .rate_exp_wr (rate_exp_wr),
        .target_tw   (target_tw),
        .out_tw      (out_tw)
    );

    always #10 clk = ~clk;

    typedef struct {
        logic [TW_W-1:0] exp_tw;
        string           tag;
    } sb_item_t;

    sb_item_t        sb_q[$];
    int              n_cmp = 0;
    int              n_bad = 0;
    logic [TW_W-1:0] m_out = '0;
    int              m_cnt = 0;
    bit              done = 1'b0;

    function automatic logic [TW_W-1:0] bounded_move(
        input logic [TW_W-1:0] cur, input logic [TW_W-1:0] tgt,
        input logic [TW_W-1:0] k);
        if (tgt >= cur) begin
            return (tgt - cur <= k) ? tgt : cur + k;
        end
        return (cur - tgt <= k) ? tgt : cur - k;
    endfunction

    // Driver: applies one clock of stimulus and queues the expected output
    task automatic drive(input bit en, input logic [TW_W-1:0] k, input int p,
                         input bit wr, input logic [TW_W-1:0] tgt, input string tag);
        sb_item_t it;
        @(negedge clk);
        lim_en      = en;
        slew_k      = k;
        rate_exp    = 4'(p);
        rate_exp_wr = wr;
        target_tw   = tgt;
        if (!en) begin
            m_out = tgt;
            m_cnt = 0;
        end else if (wr) begin
            m_cnt = 0;
        end else if (m_cnt == (1 << p) - 1) begin
            m_out = bounded_move(m_out, tgt, k);
            m_cnt = 0;
        end else begin
            m_cnt = m_cnt + 1;
        end
        it.exp_tw = m_out;
        it.tag    = tag;
        sb_q.push_back(it);
    endtask

    // Monitor: compares one queued item per clock, just after the edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb_q.size() > 0) begin
                sb_item_t it;
                it = sb_q.pop_front();
                n_cmp++;
                if (out_tw !== it.exp_tw) begin
                    n_bad++;
                    $display("FAIL %s: out_tw=%h expected=%h", it.tag, out_tw, it.exp_tw);
                end
            end
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not end, actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        n_cmp++;
        if (out_tw !== '0) begin
            n_bad++;
            $display("FAIL R1: out_tw=%h expected=%h in reset", out_tw, 48'h0);
        end
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #2;
        n_cmp++;
        if (out_tw !== '0) begin
            n_bad++;
            $display("FAIL R1: out_tw=%h expected=%h after release", out_tw, 48'h0);
        end

        // R2: bypass follows target each clock
        drive(0, 48'd5, 2, 0, 48'h1234_5678_9ABC, "R2");
        drive(0, 48'd5, 2, 0, 48'hFFFF_0000_0001, "R2");
        drive(0, 48'd5, 2, 0, 48'd1000, "R2");

        // R9/R3/R4/R6: enable with P=2, K=100, ramp up to 1500
        drive(1, 48'd100, 2, 0, 48'd1500, "R9");
        drive(1, 48'd100, 2, 0, 48'd1500, "R3");
        drive(1, 48'd100, 2, 0, 48'd1500, "R3");
        for (int i = 0; i < 20; i++) drive(1, 48'd100, 2, 0, 48'd1500, "R4");
        // R5/R6: ramp down to 1230
        for (int i = 0; i < 16; i++) drive(1, 48'd100, 2, 0, 48'd1230, "R5");
        // R6: distance exactly K lands on target
        for (int i = 0; i < 4; i++) drive(1, 48'd100, 2, 0, 48'd1130, "R6");

        // R8: K = 0 freezes
        for (int i = 0; i < 12; i++) drive(1, 48'd0, 2, 0, 48'd9999, "R8");

        // R7/R11: start above the wrap point, target just above zero, P = 0
        drive(0, 48'h0, 0, 0, 48'hFFFF_FFFF_FFF0, "R2");
        for (int i = 0; i < 6; i++) drive(1, 48'h4000_0000_0000, 0, 0, 48'h5, "R7");
        for (int i = 0; i < 4; i++) drive(1, 48'd7, 0, 0, 48'd40, "R11");

        // R10: P = 3, restart mid-count
        drive(0, 48'd50, 3, 0, 48'd0, "R2");
        for (int i = 0; i < 5; i++) drive(1, 48'd50, 3, 0, 48'd1000, "R10");
        drive(1, 48'd50, 3, 1, 48'd1000, "R10");
        for (int i = 0; i < 18; i++) drive(1, 48'd50, 3, 0, 48'd1000, "R10");

        // R9: re-enable after bypass holds the last bypassed word
        drive(0, 48'd50, 1, 0, 48'd777, "R2");
        drive(1, 48'd50, 1, 0, 48'd100, "R9");
        drive(1, 48'd50, 1, 0, 48'd100, "R9");
        drive(1, 48'd50, 1, 0, 48'd100, "R9");

        repeat (3) @(posedge clk);
        #4;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule